// File: doc/BRIEF.md
# UART FIFO Control and Trigger Logic

This block holds the receive and transmit byte queues of one UART channel, together with the 8-bit control register that governs them. Software writes the control register to turn queuing on or off, to empty either queue, and to choose the fill levels at which the two interrupt flags change state. The serial side of the channel pushes received bytes and pops bytes to send. The host side pops received bytes and pushes bytes to transmit. Both sides read the fill counts.

When queuing is off, each direction holds a single byte. When queuing is on, each direction holds up to 32 bytes. The receive-ready flag is set when the receive fill reaches its threshold. The transmit-empty flag is set when the transmit fill is below its threshold. A push into a full receive queue is dropped and sets a sticky overrun flag.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset both counts are 0, the register reads 0x00, `rx_ready_irq` is 0, `tx_empty_irq` is 1, `rx_overrun` is 0, and both data outputs are 0.
- R2: A write stores bits 7:6 (receive trigger code), bits 5:4 (transmit trigger code) and bit 0 (enable). From the next cycle `cfg_rdata` reads these bits in the same positions, and bits 3:1 read 0.
- R3: With enable at 1, each queue accepts up to 32 bytes and returns them in push order. A count never exceeds 32.
- R4: With enable at 0, each queue holds at most one byte.
- R5: A receive push that finds the queue full is dropped and sets `rx_overrun`. The flag stays set until the receive queue is cleared. A transmit push into a full queue is dropped silently.
- R6: A pop from an empty queue leaves the count at 0 and leaves the data output unchanged.
- R7: Writing 1 to bit 1 empties the receive queue, and writing 1 to bit 2 empties the transmit queue, both from the next cycle. The other queue is untouched. A push in the cycle of the clear is dropped. Both bits read back as 0.
- R8: A write that changes bit 0 empties both queues. A write that keeps bit 0 at its current value and has bits 2:1 at 0 empties neither queue.
- R9: `rx_ready_irq` is 1 when the receive count is at least the receive level. With enable at 1, receive codes 0, 1, 2 and 3 give levels 8, 16, 24 and 28. With enable at 0 the level is 1.
- R10: With enable at 1, `tx_empty_irq` is 1 when the transmit count is below the transmit level. Transmit codes 0, 1, 2 and 3 give levels 16, 8, 24 and 30. With enable at 0, the flag is 1 exactly when the transmit count is 0.
- R11: A pop of a non-empty queue puts the oldest byte on that queue's data output in the cycle after the pop strobe. The output then holds that byte until the next such pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register read value |
| rx_push | input | 1 | Push strobe, receive queue |
| rx_din | input | 8 | Byte pushed into the receive queue |
| rx_pop | input | 1 | Pop strobe, receive queue |
| rx_dout | output | 8 | Last byte popped from the receive queue |
| rx_count | output | 6 | Receive fill count |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| tx_push | input | 1 | Push strobe, transmit queue |
| tx_din | input | 8 | Byte pushed into the transmit queue |
| tx_pop | input | 1 | Pop strobe, transmit queue |
| tx_dout | output | 8 | Last byte popped from the transmit queue |
| tx_count | output | 6 | Transmit fill count |
| rx_ready_irq | output | 1 | Receive fill at or above threshold |
| tx_empty_irq | output | 1 | Transmit fill below threshold |

## Verification
The assertions assume that strobes are clean single-cycle levels sampled at the clock edge. They also assume that a control write is the only way a queue is cleared, so an overrun may drop only in a cycle that writes bit 1 or changes bit 0. The stimulus changes inputs only on the falling edge. It issues pushes, pops and writes freely in the same cycle, including pushes into full queues and pops of empty ones. Writes are kept rare in the mixed-traffic phase so that the queues reach their full and threshold states between clears.

// File: rtl/uart_fifo_pkg.sv
// Shared types and trigger-level tables for the UART FIFO control block.
// Assumes the 32-entry queue mode; levels are fixed character counts.
package uart_fifo_pkg;

    typedef logic [1:0] trig_code_t;

    typedef struct packed {
        trig_code_t rx_trig;
        trig_code_t tx_trig;
        logic       enable;
    } fifo_cfg_t;

    // Receive threshold in characters for each trigger code.
    function automatic int unsigned rx_level(input trig_code_t code);
        case (code)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 24;
            default: return 28;
        endcase
    endfunction

    // Transmit threshold in characters for each trigger code.
    function automatic int unsigned tx_level(input trig_code_t code);
        case (code)
            2'd0:    return 16;
            2'd1:    return 8;
            2'd2:    return 24;
            default: return 30;
        endcase
    endfunction

endpackage

// File: rtl/fifo_ctrl_reg.sv
// Control register: holds enable and trigger codes, and turns writes
// into one-cycle clear pulses for each queue. Clear bits are not stored,
// so they read back as 0. A change of the enable bit clears both queues.
module fifo_ctrl_reg
    import uart_fifo_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [7:0]      wdata,
    output fifo_cfg_t       cfg,
    output logic            rx_clr,
    output logic            tx_clr,
    output logic [7:0]      rdata
);

    logic en_change;

    // Decode clear requests from the current write.
    always_comb begin
        en_change = we && (wdata[0] != cfg.enable);
        rx_clr    = (we && wdata[1]) || en_change;
        tx_clr    = (we && wdata[2]) || en_change;
    end

    // Store the persistent fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg.rx_trig <= wdata[7:6];
            cfg.tx_trig <= wdata[5:4];
            cfg.enable  <= wdata[0];
        end
    end

    // Read value: reserved and clear bits always 0.
    assign rdata = {cfg.rx_trig, cfg.tx_trig, 3'b000, cfg.enable};

endmodule

// File: rtl/byte_fifo.sv
// Circular byte queue whose usable capacity is DEPTH when enabled and one
// entry when disabled. Assumes the caller clears it when the capacity
// changes. The output register updates only on a pop of a non-empty queue.
module byte_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          drop
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;
    logic          accept, take;

    // Wrap a pointer at DEPTH, which need not be a power of two.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Decide which requests are honoured this cycle.
    always_comb begin
        cap    = en ? CW'(DEPTH) : CW'(1);
        accept = push && !clr && (count < cap);
        take   = pop && !clr && (count != '0);
        drop   = push && !clr && (count >= cap);
    end

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= din;
    end

    // Pointers, fill count and popped-data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            dout   <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= bump(wr_ptr);
            if (take) begin
                rd_ptr <= bump(rd_ptr);
                dout   <= mem[rd_ptr];
            end
            case ({accept, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/fifo_trigger.sv
// Compares fill counts with the selected thresholds to form the two
// interrupt flags. Purely combinational from registered counts.
module fifo_trigger
    import uart_fifo_pkg::*;
#(
    parameter int CW = 6
) (
    input  fifo_cfg_t     cfg,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    output logic          rx_ready,
    output logic          tx_empty
);

    logic [CW-1:0] rx_lvl, tx_lvl;

    // Select levels, then compare in opposite senses.
    always_comb begin
        rx_lvl   = cfg.enable ? CW'(rx_level(cfg.rx_trig)) : CW'(1);
        tx_lvl   = cfg.enable ? CW'(tx_level(cfg.tx_trig)) : CW'(1);
        rx_ready = (rx_count >= rx_lvl);
        tx_empty = (tx_count <  tx_lvl);
    end

endmodule

// File: rtl/uart_fifo_ctrl.sv
// Top of the UART FIFO control block: control register, a receive and a
// transmit queue, the trigger comparators and the sticky receive overrun.
// Assumes DEPTH is at least the largest trigger level (30).
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int DW   = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_din,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_dout,
    output logic [CW-1:0] rx_count,
    output logic          rx_overrun,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_din,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_dout,
    output logic [CW-1:0] tx_count,
    output logic          rx_ready_irq,
    output logic          tx_empty_irq
);

    fifo_cfg_t cfg;
    logic      rx_clr, tx_clr, rx_drop, tx_drop_unused;

    fifo_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .cfg(cfg), .rx_clr(rx_clr), .tx_clr(tx_clr), .rdata(cfg_rdata)
    );

    byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .en(cfg.enable),
        .push(rx_push), .din(rx_din), .pop(rx_pop),
        .dout(rx_dout), .count(rx_count), .drop(rx_drop)
    );

    byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .en(cfg.enable),
        .push(tx_push), .din(tx_din), .pop(tx_pop),
        .dout(tx_dout), .count(tx_count), .drop(tx_drop_unused)
    );

    fifo_trigger #(.CW(CW)) u_trig (
        .cfg(cfg), .rx_count(rx_count), .tx_count(tx_count),
        .rx_ready(rx_ready_irq), .tx_empty(tx_empty_irq)
    );

    // Sticky overrun: set by a dropped receive push, cleared with the queue.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_overrun <= 1'b0;
        else if (rx_clr)  rx_overrun <= 1'b0;
        else if (rx_drop) rx_overrun <= 1'b1;
    end

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
// Property checker for uart_fifo_ctrl, attached through bind.
module uart_fifo_ctrl_chk #(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [7:0]    cfg_wdata,
    input logic [7:0]    cfg_rdata,
    input logic          rx_push,
    input logic          rx_pop,
    input logic [7:0]    rx_dout,
    input logic [CW-1:0] rx_count,
    input logic          rx_overrun,
    input logic [CW-1:0] tx_count,
    input logic          tx_empty_irq
);

    logic rx_cleared;
    assign rx_cleared = cfg_we && (cfg_wdata[1] || (cfg_wdata[0] != cfg_rdata[0]));

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

    // R4
    single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[0] |-> (rx_count <= 1) && (tx_count <= 1));

    // R5
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun && !rx_cleared |=> rx_overrun);

    // R5
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_overrun && !rx_push |=> !rx_overrun);

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop && (rx_count == 0) |=> $stable(rx_dout) && (rx_count <= 1));

    // R7
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[1] |=> rx_count == 0);

    // R10
    tx_idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == 0) |-> tx_empty_irq);

    // R11
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_pop |=> $stable(rx_dout));

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rx_push(rx_push), .rx_pop(rx_pop),
    .rx_dout(rx_dout), .rx_count(rx_count), .rx_overrun(rx_overrun),
    .tx_count(tx_count), .tx_empty_irq(tx_empty_irq)
);

// File: tb/uart_fifo_ctrl_bench.sv
// Self-checking bench: behavioural queue model compared every cycle,
// plus directed checks on resets, capacities, clears and thresholds.
module uart_fifo_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] rx_din = '0, tx_din = '0;
    logic [7:0] rx_dout, tx_dout;
    logic [5:0] rx_count, tx_count;
    logic       rx_overrun, rx_ready_irq, tx_empty_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    uart_fifo_ctrl u_uart_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rx_push(rx_push), .rx_din(rx_din),
        .rx_pop(rx_pop), .rx_dout(rx_dout), .rx_count(rx_count),
        .rx_overrun(rx_overrun), .tx_push(tx_push), .tx_din(tx_din),
        .tx_pop(tx_pop), .tx_dout(tx_dout), .tx_count(tx_count),
        .rx_ready_irq(rx_ready_irq), .tx_empty_irq(tx_empty_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- reference model ----------------
    byte rxq[$], txq[$];
    bit  m_en, m_ovr;
    bit [1:0] m_rxt, m_txt;
    bit [7:0] m_rxd, m_txd;

    function automatic int rx_lvl(bit en, bit [1:0] c);
        if (!en) return 1;
        case (c) 0: return 8; 1: return 16; 2: return 24; default: return 28; endcase
    endfunction

    function automatic int tx_lvl(bit [1:0] c);
        case (c) 0: return 16; 1: return 8; 2: return 24; default: return 30; endcase
    endfunction

    always @(posedge clk) begin
        int cap, sz;
        bit fr, ft;
        if (!rst_n) begin
            rxq.delete(); txq.delete();
            m_en = 0; m_ovr = 0; m_rxt = 0; m_txt = 0; m_rxd = 0; m_txd = 0;
        end else begin
            cap = m_en ? DEPTH : 1;
            fr = cfg_we && (cfg_wdata[1] || (cfg_wdata[0] != m_en));
            ft = cfg_we && (cfg_wdata[2] || (cfg_wdata[0] != m_en));
            if (fr) begin
                rxq.delete(); m_ovr = 0;
            end else begin
                sz = rxq.size();
                if (rx_pop && sz > 0) m_rxd = rxq.pop_front();
                if (rx_push) begin
                    if (sz < cap) rxq.push_back(rx_din); else m_ovr = 1;
                end
            end
            if (ft) begin
                txq.delete();
            end else begin
                sz = txq.size();
                if (tx_pop && sz > 0) m_txd = txq.pop_front();
                if (tx_push && sz < cap) txq.push_back(tx_din);
            end
            if (cfg_we) begin
                m_en = cfg_wdata[0]; m_rxt = cfg_wdata[7:6]; m_txt = cfg_wdata[5:4];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        bit e_rr, e_te;
        if (rst_n && !done) begin
            e_rr = int'(rxq.size()) >= rx_lvl(m_en, m_rxt);
            e_te = m_en ? (int'(txq.size()) < tx_lvl(m_txt)) : (txq.size() == 0);
            chk(rx_count == 6'(rxq.size()), "R3 rx_count", rx_count, rxq.size());
            chk(tx_count == 6'(txq.size()), "R3 tx_count", tx_count, txq.size());
            chk(rx_dout == m_rxd, "R11 rx_dout", rx_dout, m_rxd);
            chk(tx_dout == m_txd, "R11 tx_dout", tx_dout, m_txd);
            chk(rx_overrun == m_ovr, "R5 rx_overrun", rx_overrun, m_ovr);
            chk(rx_ready_irq == e_rr, "R9 rx_ready_irq", rx_ready_irq, e_rr);
            chk(tx_empty_irq == e_te, "R10 tx_empty_irq", tx_empty_irq, e_te);
            chk(cfg_rdata == {m_rxt, m_txt, 3'b000, m_en}, "R2 cfg_rdata",
                cfg_rdata, {m_rxt, m_txt, 3'b000, m_en});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        cfg_we = 1; cfg_wdata = d; tick(); cfg_we = 0;
    endtask

    task automatic rxpush(input logic [7:0] d);
        rx_push = 1; rx_din = d; tick(); rx_push = 0;
    endtask

    task automatic txpush(input logic [7:0] d);
        tx_push = 1; tx_din = d; tick(); tx_push = 0;
    endtask

    task automatic rxpop();
        rx_pop = 1; tick(); rx_pop = 0;
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk(rx_count == 0 && tx_count == 0, "R1 counts", rx_count + tx_count, 0);
        chk(cfg_rdata == 8'h00, "R1 cfg_rdata", cfg_rdata, 0);
        chk(!rx_ready_irq && tx_empty_irq && !rx_overrun, "R1 flags",
            {rx_ready_irq, tx_empty_irq, rx_overrun}, 3'b010);
        chk(rx_dout == 0 && tx_dout == 0, "R1 data", rx_dout, 0);

        // R4 disabled: one byte only; R5 second push drops and flags
        rxpush(8'hA1);
        rxpush(8'hA2);
        chk(rx_count == 1, "R4 rx single entry", rx_count, 1);
        chk(rx_overrun == 1, "R5 overrun set", rx_overrun, 1);
        chk(rx_ready_irq == 1, "R9 disabled level 1", rx_ready_irq, 1);
        rxpop();
        chk(rx_dout == 8'hA1, "R11 popped byte", rx_dout, 8'hA1);
        rxpop();
        chk(rx_dout == 8'hA1 && rx_count == 0, "R6 empty pop", rx_dout, 8'hA1);

        // R2 / R8 enable with all bits set
        wr(8'hFF);
        chk(cfg_rdata == 8'hF1, "R2 readback", cfg_rdata, 8'hF1);
        chk(rx_overrun == 0, "R5 overrun cleared", rx_overrun, 0);

        // R3 fill to 32, one extra dropped
        wr(8'h03);
        for (int i = 0; i < 33; i++) rxpush(8'(i));
        chk(rx_count == 32, "R3 depth 32", rx_count, 32);
        chk(rx_overrun == 1, "R5 full drop", rx_overrun, 1);
        for (int i = 0; i < 32; i++) rxpop();
        chk(rx_dout == 8'd31 && rx_count == 0, "R3 order last", rx_dout, 31);
        rxpop();
        chk(rx_dout == 8'd31, "R6 pop empty enabled", rx_dout, 31);

        // R9 receive thresholds
        for (int c = 0; c < 4; c++) begin
            int lv;
            wr({2'(c), 6'b000011});
            lv = rx_lvl(1'b1, 2'(c));
            for (int i = 0; i < lv - 1; i++) rxpush(8'(i));
            chk(rx_ready_irq == 0, "R9 below level", rx_ready_irq, 0);
            rxpush(8'h55);
            chk(rx_ready_irq == 1, "R9 at level", rx_ready_irq, 1);
        end

        // R10 transmit thresholds
        for (int c = 0; c < 4; c++) begin
            int lv;
            wr({2'b00, 2'(c), 4'b0101});
            lv = tx_lvl(2'(c));
            for (int i = 0; i < lv - 1; i++) txpush(8'(i));
            chk(tx_empty_irq == 1, "R10 below level", tx_empty_irq, 1);
            txpush(8'h66);
            chk(tx_empty_irq == 0, "R10 at level", tx_empty_irq, 0);
        end

        // R7 selective clear and clear priority over push
        wr(8'h07);
        for (int i = 0; i < 3; i++) begin
            rx_push = 1; tx_push = 1; rx_din = 8'(i); tx_din = 8'(i + 8); tick();
        end
        rx_push = 0; tx_push = 0;
        wr(8'h05);
        chk(tx_count == 0 && rx_count == 3, "R7 tx clear only", tx_count, 0);
        rx_push = 1; rx_din = 8'h77; wr(8'h03); rx_push = 0;
        chk(rx_count == 0, "R7 clear beats push", rx_count, 0);

        // R8 enable change clears; same value does not
        rxpush(8'h10); rxpush(8'h11);
        wr(8'h00);
        chk(rx_count == 0, "R8 disable clears", rx_count, 0);
        txpush(8'h20);
        chk(tx_empty_irq == 0, "R10 disabled holding", tx_empty_irq, 0);
        wr(8'h00);
        chk(tx_count == 1, "R8 same enable keeps", tx_count, 1);

        // Mixed traffic
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            rx_push = r[0] | r[1]; rx_pop = r[2] & r[3];
            tx_push = r[4] & r[5]; tx_pop = r[6] | r[7];
            rx_din = r[15:8]; tx_din = r[23:16];
            cfg_we = (r[29:24] == 6'd0);
            cfg_wdata = {r[31:30], r[9:8], 1'b0, r[10] & r[11], r[12] & r[13], ~r[14]};
            tick();
        end
        {rx_push, rx_pop, tx_push, tx_pop, cfg_we} = '0;
        tick();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule